// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block does the bookkeeping for a shared packet buffer that is split into fixed 256-byte pages. Each packet held in the buffer is named by a small packet number. The host sends commands over a valid/ready stream. It can claim pages for a packet it is about to send, claim pages for an arriving packet, give a packet back, place a packet number on the transmit queue, drop the head of the receive queue (with or without freeing its memory), and clear the whole allocator.

The block holds two first-in first-out queues of packet numbers, one for transmit and one for receive, each with an empty flag and a head value that can be read without popping it. It keeps a count of free pages and a result register that holds the last transmit claim: the packet number and a failed bit. It also raises an allocation-done flag. A receive-reserve input keeps a number of pages away from transmit claims. When that input is zero, both directions draw first-come first-served from the whole buffer. The MAC drains the transmit queue through a pop strobe.

Command stream rules: `cmd_ready` is low only while a command is being executed. The host holds `cmd_valid` and the command fields steady until it sees `cmd_ready` high at a clock edge. The transmit drain side treats `tx_empty` low as valid and `tx_pop` as ready. A pop of an empty queue does nothing.

Top module: `pba_top`

## Requirements
- R1: A command is taken on an edge where `cmd_valid` and `cmd_ready` are both high. `busy` is then high, and `cmd_ready` low, for exactly one cycle. The command's results appear on the outputs after the next edge. Opcodes: 0 none, 1 claim for transmit, 2 claim for receive, 3 allocator reset, 4 free a packet, 5 queue for transmit, 6 drop receive head, 7 drop receive head and free it.
- R2: A successful transmit claim for N pages takes the lowest packet number not in use. It lowers `free_pages` by N, clears `alloc_fail`, sets `alloc_done` and puts the number on `alloc_pnum`.
- R3: A claim fails when N is zero, when N exceeds the pages it may use, or when all packet numbers are in use. A failed transmit claim sets `alloc_fail`, clears `alloc_done`, and leaves `free_pages` and `alloc_pnum` unchanged.
- R4: Taking a transmit claim clears `alloc_done` during its busy cycle. Outside busy cycles, `alloc_done` always equals the inverse of `alloc_fail`.
- R5: A transmit claim may use only the free pages above `rx_reserve` (none if free is at or below it). A receive claim may use every free page.
- R6: A successful receive claim pushes its packet number onto the receive queue and lowers `free_pages`. It leaves the result register and `alloc_done` untouched.
- R7: Freeing a packet number that is in use returns its pages to `free_pages` and makes the number available again. Freeing a number that is not in use changes nothing.
- R8: Queue-for-transmit appends `cmd_pnum`. `tx_head` shows the oldest entry without removing it. `tx_pop` removes it on the next edge. `tx_empty` is high exactly when the queue holds nothing.
- R9: Drop-receive-head removes the head and keeps its pages in use. The freeing variant also returns the head's pages and number. On an empty receive queue, both do nothing.
- R10: After hardware reset or the allocator-reset command: `free_pages` equals `mem_size` (24), both queues are empty, `alloc_fail` is 1, `alloc_done` is 0, `alloc_pnum` is 0, and every packet number is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Command opcode |
| cmd_pages | input | PCNT_W | Pages requested by a claim |
| cmd_pnum | input | PNUM_W | Packet number for free / queue commands |
| rx_reserve | input | PCNT_W | Pages withheld from transmit claims |
| busy | output | 1 | A command is being executed |
| alloc_done | output | 1 | Last transmit claim succeeded |
| alloc_fail | output | 1 | Failed bit of the result register |
| alloc_pnum | output | PNUM_W | Packet number from the last successful transmit claim |
| free_pages | output | PCNT_W | Pages currently free |
| mem_size | output | PCNT_W | Total pages in the buffer |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_head | output | PNUM_W | Oldest transmit queue entry |
| tx_pop | input | 1 | Remove the transmit head |
| rx_empty | output | 1 | Receive queue is empty |
| rx_head | output | PNUM_W | Oldest receive queue entry |

## Verification
`busy` is due one edge after the accepting edge. Every other command result (counts, result register, queue heads and flags) is due one edge after that. The only exception is `alloc_done`, which already drops in the busy cycle of a transmit claim. A transmit pop shows its new head one edge after the strobe. The bench drives and samples on falling edges. It checks `busy` and the mid-claim `alloc_done` at the first falling edge after acceptance, and every other result at the second.

// File: rtl/pba_pkg.sv
`timescale 1ns/1ps
package pba_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_CLAIM_TX   = 3'd1,
    OP_CLAIM_RX   = 3'd2,
    OP_WIPE       = 3'd3,
    OP_GIVE_BACK  = 3'd4,
    OP_QUEUE_TX   = 3'd5,
    OP_DROP_RX    = 3'd6,
    OP_DROP_RX_GB = 3'd7
  } pba_op_e;
endpackage

// File: rtl/pba_fifo.sv
`timescale 1ns/1ps
module pba_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) begin
        slots[wr_ptr] <= din;
        wr_ptr        <= bump(wr_ptr);
      end
      if (pop_ok) rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_head_shows_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && empty && !pop && !clear) |=> (!empty && dout == $past(din)));
endmodule

// File: rtl/pba_pool.sv
`timescale 1ns/1ps
module pba_pool #(
  parameter int NUM_PAGES = 24,
  parameter int NUM_PKTS  = 18,
  parameter int PNUM_W    = 5,
  parameter int PCNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              claim_req,
  input  logic [PCNT_W-1:0] claim_pages,
  input  logic              honor_reserve,
  input  logic [PCNT_W-1:0] reserve,
  input  logic              give_req,
  input  logic [PNUM_W-1:0] give_pnum,
  output logic              claim_ok,
  output logic [PNUM_W-1:0] claim_pnum,
  output logic [PCNT_W-1:0] free_pages
);
  logic [NUM_PKTS-1:0] in_use;
  logic [PCNT_W-1:0]   held [NUM_PKTS];
  logic                any_idle;
  logic [PCNT_W-1:0]   usable;
  logic                give_hit;
  logic [PCNT_W-1:0]   give_pages;

  always_comb begin
    any_idle   = 1'b0;
    claim_pnum = '0;
    for (int i = 0; i < NUM_PKTS; i++) begin
      if (!any_idle && !in_use[i]) begin
        any_idle   = 1'b1;
        claim_pnum = PNUM_W'(i);
      end
    end
  end

  always_comb begin
    if (!honor_reserve)          usable = free_pages;
    else if (free_pages > reserve) usable = free_pages - reserve;
    else                         usable = '0;
  end

  assign claim_ok   = claim_req && any_idle && (claim_pages != '0) && (claim_pages <= usable);
  assign give_hit   = give_req && (give_pnum < PNUM_W'(NUM_PKTS)) && in_use[give_pnum];
  assign give_pages = give_hit ? held[give_pnum] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      in_use     <= '0;
      free_pages <= PCNT_W'(NUM_PAGES);
    end else begin
      free_pages <= free_pages - (claim_ok ? claim_pages : '0) + give_pages;
      if (claim_ok) begin
        in_use[claim_pnum] <= 1'b1;
        held[claim_pnum]   <= claim_pages;
      end
      if (give_hit) in_use[give_pnum] <= 1'b0;
    end
  end

  assert_free_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    free_pages <= PCNT_W'(NUM_PAGES));

  assert_claim_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_ok && !give_req && !clear) |=> free_pages == $past(free_pages) - $past(claim_pages));

  assert_stray_give_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (give_req && !give_hit && !claim_req && !clear) |=> $stable(free_pages));
endmodule

// File: rtl/pba_top.sv
`timescale 1ns/1ps
module pba_top
  import pba_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int BUF_BYTES  = 6144,
  parameter int PNUM_W     = 5,
  parameter int QDEPTH     = 18,
  parameter int PCNT_W     = $clog2(BUF_BYTES / PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [PCNT_W-1:0] cmd_pages,
  input  logic [PNUM_W-1:0] cmd_pnum,
  input  logic [PCNT_W-1:0] rx_reserve,
  output logic              busy,
  output logic              alloc_done,
  output logic              alloc_fail,
  output logic [PNUM_W-1:0] alloc_pnum,
  output logic [PCNT_W-1:0] free_pages,
  output logic [PCNT_W-1:0] mem_size,
  output logic              tx_empty,
  output logic [PNUM_W-1:0] tx_head,
  input  logic              tx_pop,
  output logic              rx_empty,
  output logic [PNUM_W-1:0] rx_head
);
  localparam int NUM_PAGES = BUF_BYTES / PAGE_BYTES;

  pba_op_e           pend_op;
  logic              pend_valid;
  logic [PCNT_W-1:0] pend_pages;
  logic [PNUM_W-1:0] pend_pnum;
  logic              take;
  logic              wipe, claim_req, claim_ok, give_req, tx_push, rx_push, rx_pop;
  logic [PNUM_W-1:0] claim_pnum, give_pnum;
  logic              tx_full, rx_full;

  assign cmd_ready = !pend_valid;
  assign busy      = pend_valid;
  assign take      = cmd_valid && cmd_ready;
  assign mem_size  = PCNT_W'(NUM_PAGES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_op    <= OP_NOP;
      pend_pages <= '0;
      pend_pnum  <= '0;
    end else begin
      pend_valid <= take;
      if (take) begin
        pend_op    <= pba_op_e'(cmd_op);
        pend_pages <= cmd_pages;
        pend_pnum  <= cmd_pnum;
      end
    end
  end

  assign wipe      = pend_valid && (pend_op == OP_WIPE);
  assign claim_req = pend_valid && (pend_op == OP_CLAIM_TX || pend_op == OP_CLAIM_RX);
  assign give_req  = pend_valid && (pend_op == OP_GIVE_BACK ||
                                    (pend_op == OP_DROP_RX_GB && !rx_empty));
  assign give_pnum = (pend_op == OP_GIVE_BACK) ? pend_pnum : rx_head;
  assign tx_push   = pend_valid && (pend_op == OP_QUEUE_TX) && !tx_full;
  assign rx_push   = pend_valid && (pend_op == OP_CLAIM_RX) && claim_ok;
  assign rx_pop    = pend_valid && (pend_op == OP_DROP_RX || pend_op == OP_DROP_RX_GB);

  pba_pool #(
    .NUM_PAGES(NUM_PAGES), .NUM_PKTS(QDEPTH), .PNUM_W(PNUM_W), .PCNT_W(PCNT_W)
  ) u_pool (
    .clk(clk), .rst_n(rst_n), .clear(wipe),
    .claim_req(claim_req), .claim_pages(pend_pages),
    .honor_reserve(pend_op == OP_CLAIM_TX), .reserve(rx_reserve),
    .give_req(give_req), .give_pnum(give_pnum),
    .claim_ok(claim_ok), .claim_pnum(claim_pnum), .free_pages(free_pages)
  );

  pba_fifo #(.W(PNUM_W), .DEPTH(QDEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(wipe),
    .push(tx_push), .din(pend_pnum), .pop(tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  pba_fifo #(.W(PNUM_W), .DEPTH(QDEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(wipe),
    .push(rx_push), .din(claim_pnum), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      alloc_fail <= 1'b1;
      alloc_done <= 1'b0;
      alloc_pnum <= '0;
    end else if (take && pba_op_e'(cmd_op) == OP_CLAIM_TX) begin
      alloc_done <= 1'b0;
    end else if (pend_valid && pend_op == OP_CLAIM_TX) begin
      alloc_fail <= !claim_ok;
      alloc_done <= claim_ok;
      if (claim_ok) alloc_pnum <= claim_pnum;
    end
  end

  assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);
  assert_busy_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_done_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (alloc_done == !alloc_fail));
  assert_wipe_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (free_pages == mem_size && tx_empty && rx_empty && alloc_fail));
  assert_rx_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
endmodule

// File: tb/pba_top_test.sv
`timescale 1ns/1ps
module pba_top_test;
  localparam int PW = 5;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [CW-1:0] cmd_pages = '0;
  logic [PW-1:0] cmd_pnum = '0;
  logic [CW-1:0] rx_reserve = '0;
  logic          busy, alloc_done, alloc_fail;
  logic [PW-1:0] alloc_pnum, tx_head, rx_head;
  logic [CW-1:0] free_pages, mem_size;
  logic          tx_empty, rx_empty;
  logic          tx_pop = 1'b0;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pba_top uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pages(cmd_pages), .cmd_pnum(cmd_pnum),
    .rx_reserve(rx_reserve), .busy(busy), .alloc_done(alloc_done),
    .alloc_fail(alloc_fail), .alloc_pnum(alloc_pnum), .free_pages(free_pages),
    .mem_size(mem_size), .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
    .rx_empty(rx_empty), .rx_head(rx_head)
  );

  task automatic check(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Offers one command, checks busy in the cycle after acceptance, returns
  // at the falling edge where all results are due.
  task automatic send(input int op, input int pages, input int pnum, input bit mid_claim = 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pages = CW'(pages); cmd_pnum = PW'(pnum);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 busy after accept", busy, 1);
    check("R1 ready low while busy", cmd_ready, 0);
    if (mid_claim) check("R4 done cleared in busy cycle", alloc_done, 0);
    @(negedge clk);
    check("R1 busy drops", busy, 0);
  endtask

  task automatic do_tx_pop();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R10 free after reset", free_pages, 24);
    check("R10 mem_size", mem_size, 24);
    check("R10 tx empty", tx_empty, 1);
    check("R10 rx empty", rx_empty, 1);
    check("R10 fail set", alloc_fail, 1);
    check("R10 done clear", alloc_done, 0);
    check("R10 pnum zero", alloc_pnum, 0);
    check("R1 ready idle", cmd_ready, 1);
  endtask

  task automatic t_claim_tx();
    send(1, 4, 0, 1);
    check("R2 pnum first", alloc_pnum, 0);
    check("R2 free", free_pages, 20);
    check("R2 done", alloc_done, 1);
    check("R2 fail", alloc_fail, 0);
    send(1, 6, 0, 1);
    check("R2 pnum second", alloc_pnum, 1);
    check("R2 free second", free_pages, 14);
    check("R4 done again", alloc_done, 1);
  endtask

  task automatic t_claim_fail();
    send(1, 0, 0, 1);
    check("R3 zero pages fail", alloc_fail, 1);
    check("R3 zero pages done", alloc_done, 0);
    check("R3 free kept", free_pages, 14);
    check("R3 pnum kept", alloc_pnum, 1);
    send(1, 15, 0, 1);
    check("R3 too many fail", alloc_fail, 1);
    check("R3 free kept 2", free_pages, 14);
  endtask

  task automatic t_reserve();
    rx_reserve = CW'(10);
    send(1, 5, 0, 1);
    check("R5 tx blocked by reserve", alloc_fail, 1);
    check("R5 free kept", free_pages, 14);
    send(2, 5, 0);
    check("R5 rx ignores reserve", free_pages, 9);
    check("R6 rx queue filled", rx_empty, 0);
    check("R6 rx head pnum", rx_head, 2);
    check("R6 result untouched", alloc_fail, 1);
    check("R6 done untouched", alloc_done, 0);
    rx_reserve = '0;
  endtask

  task automatic t_tx_queue();
    send(5, 0, 1);
    send(5, 0, 0);
    check("R8 tx not empty", tx_empty, 0);
    check("R8 head oldest", tx_head, 1);
    check("R8 head stays", tx_head, 1);
    do_tx_pop();
    check("R8 head after pop", tx_head, 0);
    check("R8 still not empty", tx_empty, 0);
    do_tx_pop();
    check("R8 empty after drain", tx_empty, 1);
    do_tx_pop();
    check("R8 pop on empty", tx_empty, 1);
  endtask

  task automatic t_give_back();
    send(4, 0, 0);
    check("R7 pages returned", free_pages, 13);
    send(4, 0, 0);
    check("R7 stray free ignored", free_pages, 13);
    send(4, 0, 20);
    check("R7 out of range ignored", free_pages, 13);
    send(1, 1, 0, 1);
    check("R7 number reused", alloc_pnum, 0);
    check("R7 free after reuse", free_pages, 12);
  endtask

  task automatic t_rx_drop();
    send(2, 2, 0);
    check("R6 second rx free", free_pages, 10);
    check("R8 rx head oldest", rx_head, 2);
    send(6, 0, 0);
    check("R9 drop keeps pages", free_pages, 10);
    check("R9 next head", rx_head, 3);
    send(7, 0, 0);
    check("R9 drop and free", free_pages, 12);
    check("R9 rx empty", rx_empty, 1);
    send(6, 0, 0);
    check("R9 drop on empty", rx_empty, 1);
    send(7, 0, 0);
    check("R9 free-drop on empty", free_pages, 12);
  endtask

  task automatic t_exhaust_and_wipe();
    send(3, 0, 0);
    check("R10 wipe free", free_pages, 24);
    check("R10 wipe fail", alloc_fail, 1);
    send(2, 1, 0);
    check("R6 rx after wipe", rx_head, 0);
    for (int i = 1; i < 18; i++) begin
      send(1, 1, 0);
      check("R2 sequential pnum", alloc_pnum, i);
    end
    check("R2 free after many", free_pages, 6);
    send(1, 1, 0, 1);
    check("R3 no numbers left", alloc_fail, 1);
    check("R3 free unchanged", free_pages, 6);
    send(5, 0, 5);
    check("R8 queued", tx_empty, 0);
    send(3, 0, 0);
    check("R10 wipe free", free_pages, 24);
    check("R10 wipe tx", tx_empty, 1);
    check("R10 wipe rx", rx_empty, 1);
    check("R10 wipe fail bit", alloc_fail, 1);
    check("R10 wipe done", alloc_done, 0);
    check("R10 wipe pnum", alloc_pnum, 0);
    send(1, 24, 0);
    check("R10 all pnums free", alloc_pnum, 0);
    check("R5 whole buffer with no reserve", free_pages, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_claim_tx();
    t_claim_fail();
    t_reserve();
    t_tx_queue();
    t_give_back();
    t_rx_drop();
    t_exhaust_and_wipe();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule